// File: doc/BRIEF.md
# Multi-Target SPI Master Controller

This block is the controller side of a serial peripheral bus that several peripherals share. The clock, controller-out and controller-in lines are common to all of them. Each peripheral has its own active-low select line. For every peripheral the block stores a settings entry: idle clock level, sampling phase, clock divider and frame length. Software or a sequencer writes these entries through a simple write port.

A request names a target and supplies a transmit word. On acceptance the controller copies that target's settings. It parks the serial clock at the target's idle level, then pulls only that target's select line low. It exchanges the frame in full duplex, most significant bit first, and captures one input bit for every bit it sends. When the select line is released, it presents the received word with a one-cycle done pulse. A new request waits on a valid/ready handshake until the controller is free again. The bus has no acknowledge and no addressing; a target is chosen only through its select line.

Top module: `spi_mm_ctrl`

## Requirements
- R1: After reset all select lines are high, the serial clock and controller-out line are low, ready is high, done is low and the received word is zero.
- R2: On the clock edge that accepts a request, the serial clock moves to the target's idle level (0 when its polarity bit is 0, 1 when it is 1). All select lines are still high in that cycle.
- R3: One cycle after acceptance, only the requested target's select line goes low, and it stays low for the whole frame. At no time is more than one select line low.
- R4: A half period of the serial clock is divider+1 system clocks (divider 0 to 255). The first clock edge comes divider+1 cycles after select assertion. A frame has exactly 2×length edges, and the select line is released divider+1 cycles after the last edge.
- R5: With phase bit 0, the first data bit appears on the controller-out line when the select line goes low. Data changes on trailing edges and is sampled on leading edges.
- R6: With phase bit 1, the controller-out line is low until the first edge. Data changes on leading edges and is sampled on trailing edges.
- R7: Data goes out most significant bit first, starting at bit length-1 of the transmit word. The received word is right-aligned in its low length bits, with the first sampled bit highest and the upper bits zero.
- R8: Done is a single-cycle pulse in the cycle the select line returns high. The received word is valid from that cycle and is held until the next completion.
- R9: Ready is low from acceptance until the done cycle. A request presented during that time is held off and is accepted only once ready returns.
- R10: Stored frame lengths are clamped to 8..32: a written value below 8 is stored as 8, and one above 32 is stored as 32.
- R11: Settings are copied at acceptance, so a write to the active target's entry during a frame has no effect until that target's next request.
- R12: The controller-out line is low whenever no select line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for a settings entry |
| cfg_sel | input | TGT_W (2) | Entry to write |
| cfg_cpol | input | 1 | Idle clock level for the entry |
| cfg_cpha | input | 1 | Sampling phase for the entry |
| cfg_div | input | DIV_W (8) | Half-period divider for the entry |
| cfg_len | input | LEN_W (6) | Frame length in bits (clamped) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller free to accept |
| req_tgt | input | TGT_W (2) | Target index of the request |
| req_data | input | MAX_BITS (32) | Transmit word, low length bits used |
| done | output | 1 | Frame complete pulse |
| rx_data | output | MAX_BITS (32) | Received word |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Controller-out data |
| miso | input | 1 | Controller-in data |
| ss_n | output | NUM_TGT (4) | Active-low select, one per target |

## Verification
A wrong edge counter or divider count moves a clock edge or the select release by at least one system cycle. A bad phase or shift register flips the controller-out line within the same half period. Because the bench model predicts every output in every cycle, such faults appear at the ports within one half period of the fault. A wrong target latch shows the very cycle the select goes low. Stale or corrupted settings show on the first edge of the next frame. Received-word errors appear only at the done pulse, at most one frame later.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_RUN   = 2'd2
   } spi_mm_state_e;

endpackage

// File: rtl/spi_mm_cfg_bank.sv
module spi_mm_cfg_bank #(
   parameter int NUM_TGT  = 4,
   parameter int MIN_BITS = 8,
   parameter int MAX_BITS = 32,
   parameter int DIV_W    = 8,
   parameter int TGT_W    = 2,
   parameter int LEN_W    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [TGT_W-1:0] wr_sel,
   input  logic             wr_cpol,
   input  logic             wr_cpha,
   input  logic [DIV_W-1:0] wr_div,
   input  logic [LEN_W-1:0] wr_len,
   input  logic [TGT_W-1:0] rd_sel,
   output logic             rd_cpol,
   output logic             rd_cpha,
   output logic [DIV_W-1:0] rd_div,
   output logic [LEN_W-1:0] rd_len
);

   localparam logic [LEN_W-1:0] LEN_LO = LEN_W'(MIN_BITS);
   localparam logic [LEN_W-1:0] LEN_HI = LEN_W'(MAX_BITS);

   logic [LEN_W-1:0]   len_clamped;
   logic [NUM_TGT-1:0] cpol_all;
   logic [NUM_TGT-1:0] cpha_all;
   logic [DIV_W-1:0]   div_all [NUM_TGT];
   logic [LEN_W-1:0]   len_all [NUM_TGT];

   always_comb begin
      if (wr_len < LEN_LO)      len_clamped = LEN_LO;
      else if (wr_len > LEN_HI) len_clamped = LEN_HI;
      else                      len_clamped = wr_len;
   end

   for (genvar g = 0; g < NUM_TGT; g++) begin : g_ent
      logic             cpol_r;
      logic             cpha_r;
      logic [DIV_W-1:0] div_r;
      logic [LEN_W-1:0] len_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cpol_r <= 1'b0;
            cpha_r <= 1'b0;
            div_r  <= '0;
            len_r  <= LEN_LO;
         end else if (wr_en && (wr_sel == TGT_W'(g))) begin
            cpol_r <= wr_cpol;
            cpha_r <= wr_cpha;
            div_r  <= wr_div;
            len_r  <= len_clamped;
         end
      end

      assign cpol_all[g] = cpol_r;
      assign cpha_all[g] = cpha_r;
      assign div_all[g]  = div_r;
      assign len_all[g]  = len_r;
   end

   always_comb begin
      rd_cpol = cpol_all[0];
      rd_cpha = cpha_all[0];
      rd_div  = div_all[0];
      rd_len  = len_all[0];
      for (int i = 1; i < NUM_TGT; i++) begin
         if (rd_sel == TGT_W'(i)) begin
            rd_cpol = cpol_all[i];
            rd_cpha = cpha_all[i];
            rd_div  = div_all[i];
            rd_len  = len_all[i];
         end
      end
   end

endmodule

// File: rtl/spi_mm_engine.sv
module spi_mm_engine
   import spi_mm_pkg::*;
#(
   parameter int NUM_TGT  = 4,
   parameter int MAX_BITS = 32,
   parameter int DIV_W    = 8,
   parameter int TGT_W    = 2,
   parameter int LEN_W    = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [TGT_W-1:0]    req_tgt,
   input  logic [MAX_BITS-1:0] req_data,
   input  logic                cfg_cpol,
   input  logic                cfg_cpha,
   input  logic [DIV_W-1:0]    cfg_div,
   input  logic [LEN_W-1:0]    cfg_len,
   input  logic                miso,
   output logic                sck,
   output logic                mosi,
   output logic [NUM_TGT-1:0]  ss_n,
   output logic                done,
   output logic [MAX_BITS-1:0] rx_data
);

   localparam int EDGE_W = LEN_W + 1;

   spi_mm_state_e       state_q;
   logic [TGT_W-1:0]    tgt_q;
   logic                cpha_q;
   logic [DIV_W-1:0]    div_q;
   logic [LEN_W-1:0]    len_q;
   logic [DIV_W-1:0]    cnt_q;
   logic [EDGE_W-1:0]   edge_q;
   logic [MAX_BITS-1:0] tx_q;
   logic [MAX_BITS-1:0] rx_q;
   logic [NUM_TGT-1:0]  sel_oh;
   logic [EDGE_W-1:0]   edge_nx;
   logic [EDGE_W-1:0]   edge_total;
   logic                smp_edge;
   logic                lnch_edge;

   assign req_ready  = (state_q == ST_IDLE);
   assign edge_nx    = EDGE_W'(edge_q + EDGE_W'(1));
   assign edge_total = {len_q, 1'b0};
   // new edge is leading when its number is odd (edge_q even)
   assign smp_edge   = (~edge_q[0]) ^ cpha_q;
   assign lnch_edge  = ~smp_edge && (edge_nx != edge_total);

   always_comb begin
      for (int i = 0; i < NUM_TGT; i++) sel_oh[i] = (tgt_q == TGT_W'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         tgt_q   <= '0;
         cpha_q  <= 1'b0;
         div_q   <= '0;
         len_q   <= '0;
         cnt_q   <= '0;
         edge_q  <= '0;
         tx_q    <= '0;
         rx_q    <= '0;
         sck     <= 1'b0;
         mosi    <= 1'b0;
         ss_n    <= '1;
         done    <= 1'b0;
         rx_data <= '0;
      end else begin
         done <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  tgt_q   <= req_tgt;
                  cpha_q  <= cfg_cpha;
                  div_q   <= cfg_div;
                  len_q   <= cfg_len;
                  sck     <= cfg_cpol;
                  tx_q    <= req_data << (MAX_BITS - int'(cfg_len));
                  rx_q    <= '0;
                  edge_q  <= '0;
                  state_q <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               ss_n  <= ~sel_oh;
               cnt_q <= div_q;
               if (!cpha_q) begin
                  mosi <= tx_q[MAX_BITS-1];
                  tx_q <= tx_q << 1;
               end
               state_q <= ST_RUN;
            end
            ST_RUN: begin
               if (cnt_q != '0) begin
                  cnt_q <= cnt_q - DIV_W'(1);
               end else begin
                  cnt_q <= div_q;
                  if (edge_q == edge_total) begin
                     ss_n    <= '1;
                     mosi    <= 1'b0;
                     done    <= 1'b1;
                     rx_data <= rx_q;
                     state_q <= ST_IDLE;
                  end else begin
                     sck    <= ~sck;
                     edge_q <= edge_nx;
                     if (smp_edge)  rx_q <= {rx_q[MAX_BITS-2:0], miso};
                     if (lnch_edge) begin
                        mosi <= tx_q[MAX_BITS-1];
                        tx_q <= tx_q << 1;
                     end
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/spi_mm_ctrl.sv
module spi_mm_ctrl #(
   parameter int NUM_TGT  = 4,
   parameter int MIN_BITS = 8,
   parameter int MAX_BITS = 32,
   parameter int DIV_W    = 8,
   localparam int TGT_W   = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1,
   localparam int LEN_W   = $clog2(MAX_BITS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [TGT_W-1:0]    cfg_sel,
   input  logic                cfg_cpol,
   input  logic                cfg_cpha,
   input  logic [DIV_W-1:0]    cfg_div,
   input  logic [LEN_W-1:0]    cfg_len,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [TGT_W-1:0]    req_tgt,
   input  logic [MAX_BITS-1:0] req_data,
   output logic                done,
   output logic [MAX_BITS-1:0] rx_data,
   output logic                sck,
   output logic                mosi,
   input  logic                miso,
   output logic [NUM_TGT-1:0]  ss_n
);

   if (NUM_TGT < 1) begin : g_bad_tgt
      $error("spi_mm_ctrl: NUM_TGT must be at least 1");
   end
   if (MIN_BITS < 2 || MAX_BITS < MIN_BITS) begin : g_bad_len
      $error("spi_mm_ctrl: need 2 <= MIN_BITS <= MAX_BITS");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("spi_mm_ctrl: DIV_W must be at least 1");
   end

   logic             sel_cpol;
   logic             sel_cpha;
   logic [DIV_W-1:0] sel_div;
   logic [LEN_W-1:0] sel_len;

   spi_mm_cfg_bank #(
      .NUM_TGT (NUM_TGT),
      .MIN_BITS(MIN_BITS),
      .MAX_BITS(MAX_BITS),
      .DIV_W   (DIV_W),
      .TGT_W   (TGT_W),
      .LEN_W   (LEN_W)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_we),
      .wr_sel (cfg_sel),
      .wr_cpol(cfg_cpol),
      .wr_cpha(cfg_cpha),
      .wr_div (cfg_div),
      .wr_len (cfg_len),
      .rd_sel (req_tgt),
      .rd_cpol(sel_cpol),
      .rd_cpha(sel_cpha),
      .rd_div (sel_div),
      .rd_len (sel_len)
   );

   spi_mm_engine #(
      .NUM_TGT (NUM_TGT),
      .MAX_BITS(MAX_BITS),
      .DIV_W   (DIV_W),
      .TGT_W   (TGT_W),
      .LEN_W   (LEN_W)
   ) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_ready(req_ready),
      .req_tgt  (req_tgt),
      .req_data (req_data),
      .cfg_cpol (sel_cpol),
      .cfg_cpha (sel_cpha),
      .cfg_div  (sel_div),
      .cfg_len  (sel_len),
      .miso     (miso),
      .sck      (sck),
      .mosi     (mosi),
      .ss_n     (ss_n),
      .done     (done),
      .rx_data  (rx_data)
   );

endmodule

// File: rtl/spi_mm_ctrl_chk.sv
module spi_mm_ctrl_chk #(
   parameter int NUM_TGT = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_TGT-1:0] ss_n,
   input logic               mosi,
   input logic               done,
   input logic               req_ready
);

   assert_one_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~ss_n) <= 1);

   assert_select_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!(&ss_n) && !(&$past(ss_n))) |-> (ss_n == $past(ss_n)));

   assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(&ss_n) |-> !req_ready);

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_at_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((&ss_n) && !(&$past(ss_n)) && req_ready));

   assert_mosi_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (&ss_n) |-> !mosi);

endmodule

bind spi_mm_ctrl spi_mm_ctrl_chk #(.NUM_TGT(NUM_TGT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ss_n     (ss_n),
   .mosi     (mosi),
   .done     (done),
   .req_ready(req_ready)
);

// File: tb/spi_mm_ctrl_bench.sv
module spi_mm_ctrl_bench;

   localparam int NT = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic        cfg_cpol = 1'b0;
   logic        cfg_cpha = 1'b0;
   logic [7:0]  cfg_div = '0;
   logic [5:0]  cfg_len = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_tgt = '0;
   logic [31:0] req_data = '0;
   logic        done;
   logic [31:0] rx_data;
   logic        sck;
   logic        mosi;
   logic        miso = 1'b0;
   logic [3:0]  ss_n;

   spi_mm_ctrl u_spi_mm_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
      .cfg_div(cfg_div), .cfg_len(cfg_len),
      .req_valid(req_valid), .req_ready(req_ready), .req_tgt(req_tgt), .req_data(req_data),
      .done(done), .rx_data(rx_data), .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
   );

   always #5 clk = ~clk;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   // model settings
   int m_cpol [NT];
   int m_cpha [NT];
   int m_div  [NT];
   int m_len  [NT];
   // request queue
   int      q_tgt  [$];
   longint  q_data [$];
   longint  q_resp [$];
   // active transfer
   bit      active = 1'b0;
   int      n, a_tgt, a_cpol, a_cpha, hp, ln;
   longint  a_data, a_resp;
   longint  exp_rx = 0;
   int      m_sck = 0;
   bit      m_ready = 1'b1;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("[TB] FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int clampl(input int v);
      if (v < 8) return 8;
      if (v > 32) return 32;
      return v;
   endfunction

   task automatic step();
      bit     pacc, pcfg;
      int     ps, pcp, pch, pdv, pln;
      int     e_sck, e_mosi, e_done, e_rdy, e_miso;
      longint e_ss;
      pacc = req_valid && m_ready;
      pcfg = cfg_we;
      ps = cfg_sel; pcp = cfg_cpol; pch = cfg_cpha; pdv = cfg_div; pln = cfg_len;
      @(negedge clk);
      if (active) n++;
      if (pacc) begin
         active = 1'b1; n = 1;
         a_tgt = q_tgt[0]; a_data = q_data[0]; a_resp = q_resp[0];
         void'(q_tgt.pop_front()); void'(q_data.pop_front()); void'(q_resp.pop_front());
         a_cpol = m_cpol[a_tgt]; a_cpha = m_cpha[a_tgt];
         hp = m_div[a_tgt] + 1; ln = m_len[a_tgt];
      end
      if (pcfg) begin
         m_cpol[ps] = pcp; m_cpha[ps] = pch; m_div[ps] = pdv; m_len[ps] = clampl(pln);
      end
      e_sck = m_sck; e_ss = 64'hF; e_mosi = 0; e_done = 0; e_rdy = 1; e_miso = 0;
      if (active) begin
         e_rdy = 0;
         if (n == 1) begin
            e_sck = a_cpol;
         end else if (n < 2 + hp * (2 * ln + 1)) begin
            int e, idx, sd;
            e = (n - 2) / hp;
            if (e > 2 * ln) e = 2 * ln;
            e_sck = a_cpol ^ (e & 1);
            e_ss = 64'hF & ~(64'd1 << a_tgt);
            if (a_cpha == 0) begin
               idx = e / 2; if (idx > ln - 1) idx = ln - 1;
               e_mosi = int'((a_data >> (ln - 1 - idx)) & 1);
               sd = (e + 1) / 2;
            end else begin
               e_mosi = (e == 0) ? 0 : int'((a_data >> (ln - 1 - (e - 1) / 2)) & 1);
               sd = e / 2;
            end
            if (sd < ln) e_miso = int'((a_resp >> (ln - 1 - sd)) & 1);
         end else begin
            e_sck = a_cpol; e_done = 1; e_rdy = 1;
            exp_rx = a_resp & ((64'd1 << ln) - 1);
            active = 1'b0; m_sck = a_cpol;
         end
      end
      m_ready = !active;
      check(sck == e_sck[0], "R2/R4 sck", longint'(sck), longint'(e_sck));
      check(ss_n == e_ss[3:0], "R3 ss_n", longint'(ss_n), e_ss);
      check(mosi == e_mosi[0], "R5/R6/R7/R12 mosi", longint'(mosi), longint'(e_mosi));
      check(done == e_done[0], "R8 done", longint'(done), longint'(e_done));
      check(req_ready == e_rdy[0], "R9 ready", longint'(req_ready), longint'(e_rdy));
      check(rx_data == exp_rx[31:0], "R7/R8 rx_data", longint'(rx_data), exp_rx);
      miso = e_miso[0];
      cfg_we = 1'b0;
      if (q_tgt.size() > 0) begin
         req_valid = 1'b1; req_tgt = q_tgt[0][1:0]; req_data = q_data[0][31:0];
      end else begin
         req_valid = 1'b0;
      end
   endtask

   task automatic set_cfg(input int t, input int cp, input int ch, input int dv, input int l);
      cfg_we = 1'b1; cfg_sel = t[1:0]; cfg_cpol = cp[0]; cfg_cpha = ch[0];
      cfg_div = dv[7:0]; cfg_len = l[5:0];
      step();
   endtask

   task automatic push(input int t, input longint d, input longint r);
      q_tgt.push_back(t); q_data.push_back(d); q_resp.push_back(r);
   endtask

   task automatic drain();
      if (q_tgt.size() > 0) begin
         req_valid = 1'b1; req_tgt = q_tgt[0][1:0]; req_data = q_data[0][31:0];
      end
      while (q_tgt.size() > 0 || active) step();
      repeat (3) step();
   endtask

   initial begin
      for (int i = 0; i < NT; i++) begin
         m_cpol[i] = 0; m_cpha[i] = 0; m_div[i] = 0; m_len[i] = 8;
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      check(ss_n == 4'hF, "R1 ss_n", longint'(ss_n), 64'hF);
      check(sck == 1'b0, "R1 sck", longint'(sck), 0);
      check(mosi == 1'b0, "R1 mosi", longint'(mosi), 0);
      check(req_ready == 1'b1, "R1 ready", longint'(req_ready), 1);
      check(done == 1'b0, "R1 done", longint'(done), 0);
      check(rx_data == 32'd0, "R1 rx_data", longint'(rx_data), 0);
      rst_n = 1'b1;
      step();
      // per-target settings: four modes, four rates
      set_cfg(0, 0, 0, 0, 8);
      set_cfg(1, 0, 1, 2, 16);
      set_cfg(2, 1, 0, 1, 12);
      set_cfg(3, 1, 1, 3, 32);
      // back-to-back requests: later ones held off (R9)
      push(0, 64'hA5, 64'h3C);
      push(1, 64'h1234, 64'hBEEF);
      push(2, 64'hF0F, 64'h9A5);
      push(3, 64'hDEADBEEF, 64'h87654321);
      push(0, 64'h81, 64'h7E);
      drain();
      // R10 clamping of lengths
      set_cfg(1, 1, 1, 0, 3);
      set_cfg(2, 0, 0, 0, 40);
      push(1, 64'hFF, 64'h55);
      push(2, 64'hC3A55A3C, 64'h0F0F1234);
      drain();
      // R11 write to active target during a frame
      push(3, 64'h13579BDF, 64'h2468ACE0);
      req_valid = 1'b1; req_tgt = 2'd3; req_data = 32'h13579BDF;
      while (!active) step();
      repeat (6) step();
      set_cfg(3, 0, 0, 0, 8);
      while (active) step();
      push(3, 64'h6D, 64'hB2);
      drain();
      // reuse of same target with different data, idle gap
      repeat (5) step();
      push(0, 64'h00, 64'hFF);
      push(0, 64'hFF, 64'h00);
      drain();
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!finished) begin
         tests++; fails++;
         $display("[TB] FAIL watchdog expired actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule